// File: doc/BRIEF.md
# CELP excitation codebook search

This block picks the best excitation codeword for one target vector of five fixed-point samples. The excitation codebook is split into 128 shape vectors and 8 signed gain levels, which together give 1024 codewords. For each shape, a dedicated lane correlates the captured target with the shape. The lane places that correlation against a ladder of thresholds to choose one gain level. It then reads the shape's gain-scaled energy term at that gain index and forms a distortion value.

The 128 distortions, each tagged with its codeword index, are then reduced to a single winner. A pipeline of halving fold stages does this: each stage compares entry i with entry i + half and keeps the better of the two. After seven stages one candidate is left. Its 10-bit index is presented together with a one-cycle done pulse.

The block is used once per speech vector. A start strobe captures the target. Seven cycles later the result appears, and the block can then take the next vector.

Top module: `celp_cb_search`

## Requirements
- R1: While reset is asserted and after its release, until the first search completes, `done_o` is 0 and `index_o` is 0.
- R2: The shape ROM holds, for shape j < 64 and sample k in 0..4, the value s(j,k) = (((13·j + 29·k + 7·j·k) mod 31) − 15) · 64, and s(j+64,k) = −s(j,k). Sample k of the target lies at `target_i` bits 16k+15 down to 16k (two's complement).
- R3: The correlation of shape j is p(j) = Σk target(k)·s(j,k). It is computed exactly in a 48-bit signed accumulator, so full-scale targets cannot overflow it.
- R4: The gain index gi of shape j counts the thresholds m = 0..6 for which p(j) > (m − 3)·2^20. The gain value is g = 2·gi − 7.
- R5: The distortion of shape j is D(j) = g²·E(j) − 2·g·p(j), where E(j) = Σk s(j,k)². The term g²·E(j) is read from a per-shape table indexed by gi.
- R6: `index_o` is {shape[6:0], gain[2:0]} of the shape with minimum D. Among equal distortions the lower shape number wins.
- R7: `done_o` is high for exactly one cycle. That cycle follows the 7th rising edge after the edge that accepted the start.
- R8: A start is accepted on an edge only when no search is in progress. A start seen while busy is ignored. A start in the done cycle is accepted.
- R9: `index_o` keeps its value between done pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures the target when idle |
| target_i | input | 80 | Five signed 16-bit target samples, sample k at bits 16k+15:16k |
| done_o | output | 1 | One-cycle pulse when the index is valid |
| index_o | output | 10 | Winning codeword {shape, gain} |

## Verification
Two things can happen in the same cycle: the done pulse that closes one search, and the start that opens the next. The bench holds start high through a whole search while it changes the target. The search must still finish on the original target, and the held start must be taken exactly in the done cycle. The result of that second search is then judged for both value and timing. Ties are forced with an all-zero target. Every negated shape in the upper half then matches its mirror in the lower half, so the lower-index rule decides the winner.

// File: rtl/celp_cb_pkg.sv
package celp_cb_pkg;

   // Shape ROM content: lower half from a modular formula, upper half mirrored in sign
   function automatic int shape_val(input int j, input int k, input int n_shape, input int amp);
      int jj;
      int v;
      jj = j % (n_shape / 2);
      v  = ((13 * jj + 29 * k + 7 * jj * k) % 31) - 15;
      if (j >= n_shape / 2) v = -v;
      return v * amp;
   endfunction

   function automatic longint shape_energy(input int j, input int vec_len, input int n_shape, input int amp);
      longint e;
      e = 0;
      for (int k = 0; k < vec_len; k++)
         e += longint'(shape_val(j, k, n_shape, amp)) * longint'(shape_val(j, k, n_shape, amp));
      return e;
   endfunction

   // Symmetric odd gain ladder: -(G-1) .. +(G-1) in steps of two
   function automatic longint gain_val(input int gi, input int n_gain);
      return longint'(2 * gi - (n_gain - 1));
   endfunction

endpackage

// File: rtl/celp_cb_lane.sv
module celp_cb_lane #(
   parameter int     SHAPE_ID  = 0,
   parameter int     N_SHAPE   = 128,
   parameter int     N_GAIN    = 8,
   parameter int     VEC_LEN   = 5,
   parameter int     SAMP_W    = 16,
   parameter int     ACC_W     = 48,
   parameter int     SHAPE_AMP = 64,
   parameter longint TH_STEP   = 64'sd1048576,
   localparam int    GAIN_W    = $clog2(N_GAIN)
) (
   input  logic [VEC_LEN*SAMP_W-1:0] tgt_i,
   output logic signed [ACC_W-1:0]   dist_o,
   output logic [GAIN_W-1:0]         gain_o
);
   import celp_cb_pkg::*;

   localparam longint ENERGY = shape_energy(SHAPE_ID, VEC_LEN, N_SHAPE, SHAPE_AMP);

   logic signed [ACC_W-1:0] prod [VEC_LEN];
   logic signed [ACC_W-1:0] etab [N_GAIN];
   logic signed [ACC_W-1:0] gtab [N_GAIN];
   logic signed [ACC_W-1:0] thr  [N_GAIN-1];
   logic signed [ACC_W-1:0] corr;
   logic [GAIN_W-1:0]       gidx;
   logic signed [ACC_W-1:0] gv;

   // One constant multiplier per sample of the shape
   for (genvar k = 0; k < VEC_LEN; k++) begin : g_tap
      localparam logic signed [ACC_W-1:0] CKW = ACC_W'(shape_val(SHAPE_ID, k, N_SHAPE, SHAPE_AMP));
      logic signed [SAMP_W-1:0] smp;
      assign smp     = tgt_i[k*SAMP_W +: SAMP_W];
      assign prod[k] = ACC_W'(smp) * CKW;
   end

   // Energy table indexed by gain level, plus the gain values themselves
   for (genvar g = 0; g < N_GAIN; g++) begin : g_etab
      localparam longint GV = gain_val(g, N_GAIN);
      assign etab[g] = ACC_W'(ENERGY * GV * GV);
      assign gtab[g] = ACC_W'(GV);
   end

   for (genvar m = 0; m < N_GAIN - 1; m++) begin : g_thr
      localparam longint TV = (longint'(m) - longint'(N_GAIN / 2 - 1)) * TH_STEP;
      assign thr[m] = ACC_W'(TV);
   end

   always_comb begin
      corr = '0;
      for (int k = 0; k < VEC_LEN; k++) corr += prod[k];
      gidx = '0;
      for (int m = 0; m < N_GAIN - 1; m++)
         if (corr > thr[m]) gidx = gidx + 1'b1;
   end

   assign gv     = gtab[gidx];
   assign dist_o = etab[gidx] - ((gv * corr) <<< 1);
   assign gain_o = gidx;

endmodule

// File: rtl/celp_cb_fold.sv
module celp_cb_fold #(
   parameter int  N      = 128,
   parameter int  ACC_W  = 48,
   parameter int  IDX_W  = 10,
   localparam int FOLDS  = $clog2(N)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [ACC_W-1:0] dist_i [N],
   input  logic [IDX_W-1:0]        idx_i  [N],
   output logic                    vld_o,
   output logic [IDX_W-1:0]        idx_o
);

   for (genvar s = 0; s < FOLDS; s++) begin : gen_st
      localparam int W = N >> (s + 1);
      logic signed [ACC_W-1:0] a_d [2*W];
      logic [IDX_W-1:0]        a_i [2*W];
      logic                    a_v;
      logic [IDX_W-1:0]        q_i [W];
      logic                    q_v;
      logic [W-1:0]            pick_hi;

      if (s == 0) begin : g_src
         assign a_d = dist_i;
         assign a_i = idx_i;
         assign a_v = vld_i;
      end else begin : g_src
         assign a_d = gen_st[s-1].g_keep.q_d;
         assign a_i = gen_st[s-1].q_i;
         assign a_v = gen_st[s-1].q_v;
      end

      // Upper half wins on smaller distortion, or on a tie with a smaller index
      always_comb
         for (int i = 0; i < W; i++)
            pick_hi[i] = (a_d[i+W] < a_d[i]) ||
                         ((a_d[i+W] == a_d[i]) && (a_i[i+W] < a_i[i]));

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            q_v <= 1'b0;
            for (int i = 0; i < W; i++) q_i[i] <= '0;
         end else begin
            q_v <= a_v;
            if (a_v)
               for (int i = 0; i < W; i++) q_i[i] <= pick_hi[i] ? a_i[i+W] : a_i[i];
         end

      // The last stage only has to keep the index
      if (s < FOLDS - 1) begin : g_keep
         logic signed [ACC_W-1:0] q_d [W];
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               for (int i = 0; i < W; i++) q_d[i] <= '0;
            end else if (a_v) begin
               for (int i = 0; i < W; i++) q_d[i] <= pick_hi[i] ? a_d[i+W] : a_d[i];
            end
      end
   end

   assign vld_o = gen_st[FOLDS-1].q_v;
   assign idx_o = gen_st[FOLDS-1].q_i[0];

endmodule

// File: rtl/celp_cb_search.sv
module celp_cb_search #(
   parameter int     N_SHAPE   = 128,
   parameter int     N_GAIN    = 8,
   parameter int     VEC_LEN   = 5,
   parameter int     SAMP_W    = 16,
   parameter int     ACC_W     = 48,
   parameter int     SHAPE_AMP = 64,
   parameter longint TH_STEP   = 64'sd1048576,
   localparam int    SH_W      = $clog2(N_SHAPE),
   localparam int    GAIN_W    = $clog2(N_GAIN),
   localparam int    IDX_W     = SH_W + GAIN_W,
   localparam int    FOLDS     = SH_W,
   localparam int    CNT_W     = $clog2(FOLDS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [VEC_LEN*SAMP_W-1:0] target_i,
   output logic                      done_o,
   output logic [IDX_W-1:0]          index_o
);

   if (N_SHAPE < 2 || (N_SHAPE & (N_SHAPE - 1)) != 0) begin : g_chk_shape
      $error("N_SHAPE must be a power of two of at least 2");
   end
   if (N_GAIN < 2 || (N_GAIN & (N_GAIN - 1)) != 0) begin : g_chk_gain
      $error("N_GAIN must be a power of two of at least 2");
   end
   if (ACC_W < 2 * SAMP_W + 16) begin : g_chk_acc
      $error("ACC_W too narrow for exact distortion");
   end

   logic                      busy_q;
   logic [CNT_W-1:0]          left_q;
   logic                      go_q;
   logic [VEC_LEN*SAMP_W-1:0] tgt_q;
   logic                      accept;

   logic signed [ACC_W-1:0] ldist [N_SHAPE];
   logic [GAIN_W-1:0]       lgain [N_SHAPE];
   logic [IDX_W-1:0]        lidx  [N_SHAPE];

   assign accept = start_i && !busy_q;
   assign busy_q = (left_q != '0);

   // The remaining-stage counter reaches zero on the edge that raises done
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         left_q <= '0;
         go_q   <= 1'b0;
         tgt_q  <= '0;
      end else begin
         go_q <= accept;
         if (accept) begin
            left_q <= CNT_W'(FOLDS);
            tgt_q  <= target_i;
         end else if (busy_q) begin
            left_q <= left_q - 1'b1;
         end
      end

   for (genvar j = 0; j < N_SHAPE; j++) begin : g_lane
      celp_cb_lane #(
         .SHAPE_ID (j),
         .N_SHAPE  (N_SHAPE),
         .N_GAIN   (N_GAIN),
         .VEC_LEN  (VEC_LEN),
         .SAMP_W   (SAMP_W),
         .ACC_W    (ACC_W),
         .SHAPE_AMP(SHAPE_AMP),
         .TH_STEP  (TH_STEP)
      ) u_lane (
         .tgt_i (tgt_q),
         .dist_o(ldist[j]),
         .gain_o(lgain[j])
      );
      assign lidx[j] = {SH_W'(j), lgain[j]};
   end

   celp_cb_fold #(
      .N    (N_SHAPE),
      .ACC_W(ACC_W),
      .IDX_W(IDX_W)
   ) u_fold (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (go_q),
      .dist_i(ldist),
      .idx_i (lidx),
      .vld_o (done_o),
      .idx_o (index_o)
   );

endmodule

// File: rtl/celp_cb_search_chk.sv
module celp_cb_search_chk #(
   parameter int  IDX_W = 10,
   parameter int  LAT   = 7,
   localparam int LW    = $clog2(LAT + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_i,
   input logic             done_o,
   input logic [IDX_W-1:0] index_o
);

   logic [LW-1:0] lat_q;

   // Edges since the last accepted start; parks above LAT when idle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   lat_q <= LW'(LAT + 1);
      else if (start_i && !busy_i)  lat_q <= '0;
      else if (lat_q <= LW'(LAT))   lat_q <= lat_q + 1'b1;

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == LW'(LAT)));

   a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_i) |=> busy_i);

   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_i));

   a_r9_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(index_o) |-> done_o);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q > LW'(LAT)) |-> !done_o);

endmodule

bind celp_cb_search celp_cb_search_chk #(
   .IDX_W(IDX_W),
   .LAT  (FOLDS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_i (busy_q),
   .done_o (done_o),
   .index_o(index_o)
);

// File: tb/celp_cb_search_tb_top.sv
module celp_cb_search_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [9:0] idx;
      int         cyc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [79:0] target_i = '0;
   logic        done_o;
   logic [9:0]  index_o;

   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   int   n_push  = 0;
   int   n_done  = 0;
   bit   prev_done = 1'b0;
   bit   finished  = 1'b0;
   logic [9:0] last_exp = '0;
   exp_t sb [$];

   celp_cb_search dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .target_i(target_i),
      .done_o  (done_o),
      .index_o (index_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint ref_shape(input int j, input int k);
      int jj;
      int v;
      jj = j % 64;
      v  = ((13 * jj + 29 * k + 7 * jj * k) % 31) - 15;
      if (j >= 64) v = -v;
      return longint'(v * 64);
   endfunction

   // Plain linear scan; strict less keeps the lowest shape on ties (R6)
   function automatic logic [9:0] ref_index(input logic [79:0] t);
      longint best_d;
      int     best_j;
      int     best_g;
      best_d = 0;
      best_j = 0;
      best_g = 0;
      for (int j = 0; j < 128; j++) begin
         longint p;
         longint e;
         longint g;
         longint d;
         int     gi;
         p = 0;
         e = 0;
         for (int k = 0; k < 5; k++) begin
            longint x;
            x = longint'($signed(t[k*16 +: 16]));
            p += x * ref_shape(j, k);
            e += ref_shape(j, k) * ref_shape(j, k);
         end
         gi = 0;
         for (int m = 0; m < 7; m++)
            if (p > longint'(m - 3) * 64'sd1048576) gi++;
         g = longint'(2 * gi - 7);
         d = g * g * e - 2 * g * p;
         if (j == 0 || d < best_d) begin
            best_d = d;
            best_j = j;
            best_g = gi;
         end
      end
      return {7'(best_j), 3'(best_g)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic push_exp(input logic [79:0] t);
      exp_t e;
      e.idx = ref_index(t);
      e.cyc = cyc + 7;
      sb.push_back(e);
      n_push++;
   endtask

   // Driver: one start pulse, then let the search drain
   task automatic launch(input logic [79:0] t);
      @(negedge clk);
      target_i = t;
      start_i  = 1'b1;
      @(posedge clk);
      #1;
      push_exp(t);
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   function automatic logic [79:0] pack5(input int a, input int b, input int c,
                                         input int d, input int e);
      return {16'(e), 16'(d), 16'(c), 16'(b), 16'(a)};
   endfunction

   function automatic logic [79:0] rand_vec(input int amp);
      logic [79:0] v;
      for (int k = 0; k < 5; k++) begin
         int r;
         r = int'($urandom_range(2 * amp, 0)) - amp;
         v[k*16 +: 16] = 16'(r);
      end
      return v;
   endfunction

   // Monitor: pops the scoreboard on every done pulse
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o) begin
            n_done++;
            if (sb.size() == 0) begin
               check(1'b0, "R8", "done with no search pending", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(index_o == e.idx, "R6", "winning index (R3 R4 R5 R2)",
                     longint'(index_o), longint'(e.idx));
               check(cyc == e.cyc, "R7", "done cycle", cyc, e.cyc);
               last_exp = e.idx;
            end
         end
         if (done_o && prev_done)
            check(1'b0, "R7", "done held two cycles", 1, 0);
         prev_done = done_o;
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R1", "done in reset", longint'(done_o), 0);
      check(index_o == '0, "R1", "index in reset", longint'(index_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R1", "done after reset", longint'(done_o), 0);
      check(index_o == '0, "R1", "index after reset", longint'(index_o), 0);

      // Ties between mirrored shapes: R6 lower index
      launch('0);
      // Directed patterns
      launch(pack5(1000, -2000, 3000, 500, -700));
      launch(pack5(-300, 120, 250, -80, 10));
      // Full-scale extremes exercise the accumulator width (R3)
      launch(pack5(32767, 32767, 32767, 32767, 32767));
      launch(pack5(-32768, -32768, -32768, -32768, -32768));
      launch(pack5(32767, -32768, 32767, -32768, 32767));
      // Small amplitudes spread gains across the threshold ladder (R4)
      for (int n = 0; n < 12; n++) launch(rand_vec(400));
      for (int n = 0; n < 6; n++)  launch(rand_vec(32000));

      // R9: index holds while inputs wander with no start
      @(negedge clk);
      target_i = rand_vec(20000);
      repeat (6) @(negedge clk);
      check(index_o == last_exp, "R9", "index hold", longint'(index_o), longint'(last_exp));

      // R8: start held through a search; target changes while busy; done + start coincide
      begin
         logic [79:0] ta;
         logic [79:0] tb;
         ta = pack5(700, 300, -900, 200, 50);
         tb = pack5(-150, 400, -20, 330, -260);
         @(negedge clk);
         target_i = ta;
         start_i  = 1'b1;
         @(posedge clk);
         #1;
         push_exp(ta);
         @(negedge clk);
         target_i = tb;
         repeat (7) @(negedge clk);
         check(done_o == 1'b1, "R8", "done while start held", longint'(done_o), 1);
         @(posedge clk);
         #1;
         push_exp(tb);
         @(negedge clk);
         start_i = 1'b0;
         repeat (12) @(negedge clk);
      end

      check(n_done == n_push, "R8", "done count vs accepted starts", n_done, n_push);
      check(sb.size() == 0, "R7", "searches left pending", sb.size(), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule